// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a two-wire serial slave that configures a clock generator's control registers. It only accepts writes and never returns register contents. A system clock oversamples the serial clock and data lines. Start and stop conditions are decoded from the data line while the serial clock is high. Bytes are shifted in MSB first, and the receiver acknowledges a byte by pulling the data line low through an open-drain enable.

A frame always has ten bytes. The first is the slave address. The next two are a command code and a byte count, which are taken in but not used. The last seven are data bytes. The data bytes go into shadow storage and reach the live registers only when a stop ends a complete frame whose address matched. The live registers drive:
- a frequency-select field,
- a global high-impedance request,
- a reference-bypass test request,
- one enable bit for each clock output.

Until a valid frame arrives, the registers hold their reset defaults, so the host never has to program the block.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, freq_sel_o is 0, hiz_o is 0, bypass_o is 0 and every bit of out_en_o is 1.
- R2: A frame is a start, then ten bytes in this order: address, command, count, data 0 to data 6. Data 0 bits [7:2] drive freq_sel_o, bit 1 drives hiz_o and bit 0 drives bypass_o. Data byte k (k = 1..6) bit b drives out_en_o[8*(k-1)+b].
- R3: The address byte must be 8'hD2. With any other address, no register changes and no byte is acknowledged.
- R4: The command and count byte values have no effect on the result. Both bytes must still be sent.
- R5: When the address matched, sda_oe_o is 1 during the ninth serial clock of each of the ten bytes, including the address byte. It is 0 at all other times.
- R6: Registers are committed only by a stop that follows all ten bytes. A frame ended early by a stop leaves every register unchanged.
- R7: A repeated start throws away the frame in progress and begins a new frame at the address byte.
- R8: A frame with more than ten complete bytes is thrown away, and the extra bytes are not acknowledged.
- R9: The outputs do not change while a frame is being received. They change only on the commit.
- R10: Data bits are sampled on rising edges of scl_i. A start is a falling edge of sda_i while scl_i is high, and a stop is a rising edge of sda_i while scl_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low for an acknowledge |
| freq_sel_o | output | 6 | Frequency-select field |
| hiz_o | output | 1 | Request to put all clock outputs into high impedance |
| bypass_o | output | 1 | Request to route the reference straight to the outputs |
| out_en_o | output | 48 | Per-output enable; 0 holds that output low |

## Verification
Each serial line passes through two synchronizer flops and one edge-history flop, so the block sees an edge about three system cycles after the pin moves. The acknowledge enable rises on the cycle after the eighth falling clock is detected. It clears on the cycle after the ninth falling clock. The bench samples it in the middle of the ninth clock's high phase, at least 20 cycles after it settles. A commit reaches the outputs four cycles after the stop edge on the data line. The bench checks registers at least 40 cycles after that edge. Mid-frame register checks are taken after the last data bit and before the stop, the point where an early update would already be visible.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_ACK_DONE
  } rx_state_e;

  localparam int unsigned HDR_BYTES = 3;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  // lines idle high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
  assign sda_o      = sda_ff[1];
endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
  import cfg_rx_pkg::*;
#(
  parameter int unsigned NUM_DATA   = 7,
  parameter logic [7:0]  SLAVE_ADDR = 8'hD2,
  parameter int unsigned DIDX_W     = $clog2(NUM_DATA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [DIDX_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o
);
  localparam int unsigned FRAME_LEN = HDR_BYTES + NUM_DATA;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN + 2);

  rx_state_e         state_q;
  logic [6:0]        shift_q;
  logic [2:0]        bit_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              addr_ok_q, ack_en_q, sda_oe_q;
  logic              wr_en_q, commit_q;
  logic [DIDX_W-1:0] wr_idx_q;
  logic [7:0]        wr_data_q;
  logic [7:0]        byte_w;
  logic              in_data_w;

  assign byte_w    = {shift_q, sda_i};
  assign in_data_w = (idx_q >= IDX_W'(HDR_BYTES)) && (idx_q < IDX_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      addr_ok_q <= 1'b0;
      ack_en_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      commit_q  <= 1'b0;
    end else begin
      wr_en_q  <= 1'b0;
      commit_q <= 1'b0;
      if (start_i) begin
        // a start or repeated start always begins a fresh frame
        state_q   <= ST_DATA;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        addr_ok_q <= 1'b0;
        sda_oe_q  <= 1'b0;
      end else if (stop_i) begin
        commit_q <= (state_q == ST_DATA) && (idx_q == IDX_W'(FRAME_LEN)) && addr_ok_q;
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DATA: if (scl_rise_i) begin
            shift_q   <= byte_w[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              state_q <= ST_ACK_SETUP;
              if (idx_q == '0) begin
                addr_ok_q <= (byte_w == SLAVE_ADDR);
                ack_en_q  <= (byte_w == SLAVE_ADDR);
              end else begin
                ack_en_q <= addr_ok_q && (idx_q < IDX_W'(FRAME_LEN));
              end
              if (addr_ok_q && in_data_w) begin
                wr_en_q   <= 1'b1;
                wr_idx_q  <= DIDX_W'(idx_q - IDX_W'(HDR_BYTES));
                wr_data_q <= byte_w;
              end
              if (idx_q != IDX_W'(FRAME_LEN + 1)) idx_q <= idx_q + 1'b1;
            end
          end
          ST_ACK_SETUP: if (scl_fall_i) begin
            sda_oe_q <= ack_en_q;
            state_q  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_rise_i) state_q <= ST_ACK_DONE;
          ST_ACK_DONE: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign commit_o  = commit_q;

  // R5
  ack_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_q |-> addr_ok_q);

  // R6
  commit_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> (state_q == ST_IDLE));

  // R10
  idle_until_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned NUM_DATA = 7,
  parameter int unsigned DIDX_W   = $clog2(NUM_DATA)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [DIDX_W-1:0]     wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  commit_i,
  output logic [NUM_DATA*8-1:0] live_o
);
  // byte 0 holds control fields (all off), the rest are output enables (all on)
  function automatic logic [7:0] dflt(int unsigned idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  logic [NUM_DATA*8-1:0] live_w;

  for (genvar g = 0; g < NUM_DATA; g++) begin : g_byte
    logic [7:0] shadow_q, live_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= dflt(g);
        live_q   <= dflt(g);
      end else begin
        if (wr_en_i && wr_idx_i == DIDX_W'(g)) shadow_q <= wr_data_i;
        if (commit_i) live_q <= shadow_q;
      end
    end
    assign live_w[g*8 +: 8] = live_q;
  end

  assign live_o = live_w;

  // R9
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(live_w));

  // R6
  commit_write_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !wr_en_i);
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int unsigned NUM_DATA   = 7,
  parameter logic [7:0]  SLAVE_ADDR = 8'hD2,
  parameter int unsigned FREQ_W     = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  output logic [FREQ_W-1:0]         freq_sel_o,
  output logic                      hiz_o,
  output logic                      bypass_o,
  output logic [8*(NUM_DATA-1)-1:0] out_en_o
);
  localparam int unsigned DIDX_W = $clog2(NUM_DATA);

  logic scl_rise, scl_fall, start, stop, sda_s;
  logic wr_en, commit;
  logic [DIDX_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NUM_DATA*8-1:0] live;

  cfg_line_sync i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop),
    .sda_o      (sda_s)
  );

  cfg_frame_fsm #(
    .NUM_DATA   (NUM_DATA),
    .SLAVE_ADDR (SLAVE_ADDR),
    .DIDX_W     (DIDX_W)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_s),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .commit_o   (commit)
  );

  cfg_reg_bank #(
    .NUM_DATA (NUM_DATA),
    .DIDX_W   (DIDX_W)
  ) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .live_o    (live)
  );

  assign freq_sel_o = live[7 -: FREQ_W];
  assign hiz_o      = live[1];
  assign bypass_o   = live[0];
  assign out_en_o   = live[NUM_DATA*8-1:8];
endmodule

// File: tb/test_cfg_serial_rx.sv
module test_cfg_serial_rx;
  localparam int Q = 20;
  localparam logic [55:0] DFLT = {48'hFFFF_FFFF_FFFF, 8'h00};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [5:0] freq_sel;
  logic hiz, bypass;
  logic [47:0] out_en;
  wire sda_line = m_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  logic [55:0] exp_live = DFLT;

  logic  ack_exp_q[$];
  string ack_tag_q[$];
  logic [55:0] reg_exp_q[$];
  string reg_tag_q[$];

  always #4 clk = ~clk;

  cfg_serial_rx i_cfg_serial_rx (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .freq_sel_o (freq_sel),
    .hiz_o      (hiz),
    .bypass_o   (bypass),
    .out_en_o   (out_en)
  );

  // monitors
  initial forever begin
    logic e; string t;
    wait (ack_exp_q.size() > 0);
    e = ack_exp_q.pop_front();
    t = ack_tag_q.pop_front();
    total++;
    if (sda_oe !== e) begin
      bad++;
      $display("FAIL %s ack: actual=%0b expected=%0b", t, sda_oe, e);
    end
  end

  initial forever begin
    logic [55:0] e, a; string t;
    wait (reg_exp_q.size() > 0);
    e = reg_exp_q.pop_front();
    t = reg_tag_q.pop_front();
    a = {out_en, freq_sel, hiz, bypass};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s regs: actual=%h expected=%h", t, a, e);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_reg(string tag);
    reg_exp_q.push_back(exp_live);
    reg_tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(Q);
    scl = 1'b1;   idle(Q);
    m_sda = 1'b0; idle(Q);
    scl = 1'b0;   idle(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(Q);
    scl = 1'b1;   idle(Q);
    m_sda = 1'b1; idle(2*Q);
  endtask

  task automatic send_byte(logic [7:0] b, logic exp_ack, string tag);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(Q);
      scl = 1'b1;   idle(2*Q);
      scl = 1'b0;   idle(Q);
    end
    m_sda = 1'b1; idle(Q);
    scl = 1'b1;   idle(Q);
    ack_exp_q.push_back(exp_ack);
    ack_tag_q.push_back(tag);
    idle(Q);
    scl = 1'b0;   idle(Q);
  endtask

  // sends nbytes of a frame (11th byte is an extra filler), no start/stop
  task automatic send_body(logic [7:0] addr, logic [7:0] cmd, logic [7:0] cnt,
                           logic [55:0] data, int nbytes, string tag);
    logic m = (addr == 8'hD2);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] b;
      if (k == 0) b = addr;
      else if (k == 1) b = cmd;
      else if (k == 2) b = cnt;
      else if (k < 10) b = data[(k-3)*8 +: 8];
      else b = 8'h77;
      send_byte(b, (k == 0) ? m : (m && k < 10), tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [55:0] d1, d2, d3;
    d1 = {48'h0123_4567_89AB, 8'b101101_1_1};
    d2 = {48'hF0F0_0F0F_5A5A, 8'b010010_0_1};
    d3 = {48'h1111_2222_3333, 8'b111111_1_0};

    idle(5);
    rst_ni = 1'b1;
    idle(3);
    push_reg("R1");                     // reset defaults
    ack_exp_q.push_back(1'b0); ack_tag_q.push_back("R1");

    // R2 R10 R5: full valid frame, outputs held until stop (R9)
    bus_start();
    send_body(8'hD2, 8'h5A, 8'h33, d1, 10, "R5");
    push_reg("R9");
    bus_stop();
    exp_live = d1;
    push_reg("R2");

    // R4: other command/count values, new data still applied
    bus_start();
    send_body(8'hD2, 8'hFF, 8'h00, d2, 10, "R5");
    bus_stop();
    exp_live = d2;
    push_reg("R4");

    // R3: wrong address, no ack and no change
    bus_start();
    send_body(8'hD0, 8'h00, 8'h07, d3, 10, "R3");
    bus_stop();
    push_reg("R3");

    // R6: early stop after six bytes
    bus_start();
    send_body(8'hD2, 8'h00, 8'h07, d3, 6, "R6");
    bus_stop();
    push_reg("R6");

    // R7: repeated start mid-frame, then a full frame wins
    bus_start();
    send_body(8'hD2, 8'h00, 8'h07, d1, 5, "R7");
    bus_start();
    send_body(8'hD2, 8'h00, 8'h07, d3, 10, "R7");
    bus_stop();
    exp_live = d3;
    push_reg("R7");

    // R8: over-length frame discarded, extra byte not acked
    bus_start();
    send_body(8'hD2, 8'h00, 8'h07, d2, 11, "R8");
    bus_stop();
    push_reg("R8");

    wait (ack_exp_q.size() == 0 && reg_exp_q.size() == 0);
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule